// File: doc/BRIEF.md
# Bundled-Data Transition/Level Handshake Bridge

This block joins two bundled-data channels that speak different handshake dialects. Each side has a request wire, an acknowledge wire and a data bus of `DATA_W` bits. On the transition side, every edge of request (rising or falling) announces one token, and every edge of acknowledge retires one token. On the level side, a token takes a full return-to-zero cycle: request rises, acknowledge rises, request falls, acknowledge falls. The bridge moves every token across exactly once and keeps the tokens in order.

The bridge is clocked logic that samples the incoming handshake wires. An optional synchronizer stage count (`SYNC_STAGES`, 0 for none) sits in front of the sampled request and acknowledge. The `DIR` parameter picks the orientation. With `DIR` = 0, the upstream side uses transitions and the downstream side uses levels. With `DIR` = 1, the upstream side uses levels and the downstream side uses transitions.

When the bridge sees a request event, it latches the upstream bus into an output register. It then starts the downstream handshake. The upstream side is acknowledged only after the downstream side has finished. Between request events the upstream bus may change freely and has no effect.

Top module: `hsb_phase_bridge`

## Requirements
- R1: While reset is held, and right after it is released, `dn_req`, `up_ack` and `dn_data` are all 0.
- R2: With DIR=0, each edge of `up_req`, whether rising or falling, produces exactly one rise of `dn_req`. That rise happens only while the event is unacknowledged, meaning `up_req` differs from `up_ack`.
- R3: `dn_data` equals the value `up_data` held when the request event was taken. It does not change until the next downstream request event.
- R4: With DIR=0, `dn_req` falls only after `dn_ack` has been seen high. `up_ack` toggles only after `dn_req` and `dn_ack` are both low again.
- R5: With DIR=1, each rise of `up_req` produces exactly one edge of `dn_req`. That edge happens only while `up_req` is high and `up_ack` is low.
- R6: With DIR=1, `up_ack` rises only after `dn_ack` has come to equal `dn_req`. It falls only after `up_req` has been seen low.
- R7: Changes on `up_data` while no request event is pending leave `dn_req` and `dn_data` unchanged.
- R8: Tokens leave in the order they entered. None is lost and none is delivered twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Upstream request (transition if DIR=0, level if DIR=1) |
| up_ack | output | 1 | Upstream acknowledge, same dialect as up_req |
| up_data | input | DATA_W | Upstream bundled data |
| dn_req | output | 1 | Downstream request (level if DIR=0, transition if DIR=1) |
| dn_ack | input | 1 | Downstream acknowledge, same dialect as dn_req |
| dn_data | output | DATA_W | Downstream bundled data, registered |

## Verification
A corrupted event-tracking bit or a stuck state would show up as an extra or a missing request event downstream. It would then appear as an upstream acknowledge that never arrives, within one handshake round trip. A capture enable asserted at the wrong moment would show as a downstream value that differs from the queued token, or that drifts while the request is active. The scoreboard exposes this at the next token. Tokens are checked in order against the queue, so loss and duplication both surface no later than the end of the stream.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [1:0] {
        HSB_IDLE    = 2'd0,
        HSB_WAIT_A  = 2'd1,
        HSB_WAIT_B  = 2'd2
    } hsb_state_e;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES == 0) begin : g_pass
            assign dout = din;
        end else begin : g_flops
            logic [STAGES-1:0] chain_d, chain_q;
            always_comb begin
                chain_d = {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din};
                if (STAGES == 1) chain_d = din;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
            assign dout = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hsb_tp2fp_core.sv
module hsb_tp2fp_core
    import hsb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_in,
    input  logic         ack_in,
    input  logic [W-1:0] data_in,
    output logic         ack_out,
    output logic         req_out,
    output logic [W-1:0] data_out
);
    typedef struct packed {
        hsb_state_e   st;
        logic         seen;
        logic         req_o;
        logic         ack_o;
        logic [W-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            HSB_IDLE: begin
                if (req_in != r_q.seen) begin
                    r_d.seen  = req_in;
                    r_d.data  = data_in;
                    r_d.req_o = 1'b1;
                    r_d.st    = HSB_WAIT_A;
                end
            end
            HSB_WAIT_A: begin
                if (ack_in) begin
                    r_d.req_o = 1'b0;
                    r_d.st    = HSB_WAIT_B;
                end
            end
            HSB_WAIT_B: begin
                if (!ack_in) begin
                    r_d.ack_o = ~r_q.ack_o;
                    r_d.st    = HSB_IDLE;
                end
            end
            default: r_d.st = HSB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: HSB_IDLE, seen: 1'b0, req_o: 1'b0, ack_o: 1'b0, data: '0};
        else        r_q <= r_d;
    end

    assign ack_out  = r_q.ack_o;
    assign req_out  = r_q.req_o;
    assign data_out = r_q.data;
endmodule

// File: rtl/hsb_fp2tp_core.sv
module hsb_fp2tp_core
    import hsb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_in,
    input  logic         ack_in,
    input  logic [W-1:0] data_in,
    output logic         ack_out,
    output logic         req_out,
    output logic [W-1:0] data_out
);
    typedef struct packed {
        hsb_state_e   st;
        logic         req_o;
        logic         ack_o;
        logic [W-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            HSB_IDLE: begin
                if (req_in) begin
                    r_d.data  = data_in;
                    r_d.req_o = ~r_q.req_o;
                    r_d.st    = HSB_WAIT_A;
                end
            end
            HSB_WAIT_A: begin
                if (ack_in == r_q.req_o) begin
                    r_d.ack_o = 1'b1;
                    r_d.st    = HSB_WAIT_B;
                end
            end
            HSB_WAIT_B: begin
                if (!req_in) begin
                    r_d.ack_o = 1'b0;
                    r_d.st    = HSB_IDLE;
                end
            end
            default: r_d.st = HSB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: HSB_IDLE, req_o: 1'b0, ack_o: 1'b0, data: '0};
        else        r_q <= r_d;
    end

    assign ack_out  = r_q.ack_o;
    assign req_out  = r_q.req_o;
    assign data_out = r_q.data;
endmodule

// File: rtl/hsb_phase_bridge.sv
module hsb_phase_bridge #(
    parameter int DATA_W      = 8,
    parameter int DIR         = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    output logic              up_ack,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_req,
    input  logic              dn_ack,
    output logic [DATA_W-1:0] dn_data
);
    logic req_s, ack_s;

    hsb_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .din(up_req), .dout(req_s)
    );
    hsb_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .din(dn_ack), .dout(ack_s)
    );

    generate
        if (DIR == 0) begin : g_t2l
            hsb_tp2fp_core #(.W(DATA_W)) u_core (
                .clk(clk), .rst_n(rst_n), .req_in(req_s), .ack_in(ack_s),
                .data_in(up_data), .ack_out(up_ack), .req_out(dn_req),
                .data_out(dn_data)
            );
        end else begin : g_l2t
            hsb_fp2tp_core #(.W(DATA_W)) u_core (
                .clk(clk), .rst_n(rst_n), .req_in(req_s), .ack_in(ack_s),
                .data_in(up_data), .ack_out(up_ack), .req_out(dn_req),
                .data_out(dn_data)
            );
        end
    endgenerate
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
    parameter int DIR = 0,
    parameter int W   = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         up_req,
    input logic         up_ack,
    input logic         dn_req,
    input logic         dn_ack,
    input logic [W-1:0] dn_data
);
    a_r2_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR == 0 && $rose(dn_req)) |-> (up_req != up_ack));

    a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR == 0 && $fell(dn_req)) |-> $past(dn_ack));

    a_r4_toggle_after_rtz: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR == 0 && up_ack != $past(up_ack)) |-> (!dn_req && !$past(dn_ack)));

    a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR == 0 && dn_req && $past(dn_req)) |-> $stable(dn_data));

    a_r3_data_held_t: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR != 0 && dn_req == $past(dn_req)) |-> $stable(dn_data));

    a_r5_edge_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR != 0 && dn_req != $past(dn_req)) |-> (up_req && !up_ack));

    a_r6_ack_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR != 0 && $rose(up_ack)) |-> $past(dn_ack == dn_req));

    a_r6_release_after_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        (DIR != 0 && $fell(up_ack)) |-> !$past(up_req));
endmodule

bind hsb_phase_bridge hsb_checker #(.DIR(DIR), .W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack),
    .dn_req(dn_req), .dn_ack(dn_ack), .dn_data(dn_data)
);

// File: tb/tb_hsb_phase_bridge.sv
module tb_hsb_phase_bridge;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         a_up_req = 0, a_dn_ack = 0, a_up_ack, a_dn_req;
    logic [W-1:0] a_up_data = '0, a_dn_data;
    logic         b_up_req = 0, b_dn_ack = 0, b_up_ack, b_dn_req;
    logic [W-1:0] b_up_data = '0, b_dn_data;

    hsb_phase_bridge #(.DATA_W(W), .DIR(0), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .up_req(a_up_req), .up_ack(a_up_ack),
        .up_data(a_up_data), .dn_req(a_dn_req), .dn_ack(a_dn_ack), .dn_data(a_dn_data)
    );
    hsb_phase_bridge #(.DATA_W(W), .DIR(1), .SYNC_STAGES(2)) dut_rev (
        .clk(clk), .rst_n(rst_n), .up_req(b_up_req), .up_ack(b_up_ack),
        .up_data(b_up_data), .dn_req(b_dn_req), .dn_ack(b_dn_ack), .dn_data(b_dn_data)
    );

    int checks = 0, errors = 0;
    int got_a = 0, got_b = 0;
    logic [W-1:0] qa[$], qb[$];
    logic [W-1:0] last_a = '0, last_b = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    // Transition-side sender for dut (R2, R8)
    task automatic send_a(input logic [W-1:0] v);
        @(negedge clk);
        a_up_data = v;
        qa.push_back(v);
        a_up_req = ~a_up_req;
        while (a_up_ack != a_up_req) @(negedge clk);
        last_a = v;
    endtask

    // Level-side sender for dut_rev (R5, R6)
    task automatic send_b(input logic [W-1:0] v);
        @(negedge clk);
        b_up_data = v;
        qb.push_back(v);
        b_up_req = 1'b1;
        while (!b_up_ack) @(negedge clk);
        check(b_dn_ack == b_dn_req, "R6 ack-after-match", b_dn_ack, b_dn_req);
        b_up_req = 1'b0;
        b_up_data = ~v;
        while (b_up_ack) @(negedge clk);
        last_b = v;
    endtask

    // Level-side receiver for dut (scoreboard monitor)
    initial begin : mon_a
        logic [W-1:0] exp_v;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (a_dn_req) begin
                check(qa.size() > 0, "R8 no duplicate (A)", qa.size(), 1);
                exp_v = (qa.size() > 0) ? qa.pop_front() : '0;
                check(a_dn_data == exp_v, "R3 data (A)", a_dn_data, exp_v);
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    a_up_data = ~a_up_data;
                    check(a_dn_req && a_dn_data == exp_v, "R4 held until ack (A)", a_dn_data, exp_v);
                end
                a_up_data = exp_v;
                a_dn_ack = 1'b1;
                while (a_dn_req) @(negedge clk);
                check(a_up_ack != a_up_req, "R4 no early upstream ack", a_up_ack, ~a_up_req);
                a_dn_ack = 1'b0;
                got_a++;
            end
        end
    end

    // Transition-side receiver for dut_rev
    initial begin : mon_b
        logic [W-1:0] exp_v;
        logic lvl;
        lvl = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (b_dn_req != lvl) begin
                lvl = b_dn_req;
                check(qb.size() > 0, "R5 no duplicate (B)", qb.size(), 1);
                exp_v = (qb.size() > 0) ? qb.pop_front() : '0;
                check(b_dn_data == exp_v, "R3 data (B)", b_dn_data, exp_v);
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    check(!b_up_ack && b_dn_req == lvl, "R6 no early ack (B)", b_up_ack, 0);
                end
                b_dn_ack = ~b_dn_ack;
                got_b++;
            end
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check(!a_dn_req && !a_up_ack && a_dn_data == 0, "R1 reset A", a_dn_data, 0);
        check(!b_dn_req && !b_up_ack && b_dn_data == 0, "R1 reset B", b_dn_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!a_dn_req && !a_up_ack && a_dn_data == 0, "R1 after release A", a_dn_req, 0);
        check(!b_dn_req && !b_up_ack && b_dn_data == 0, "R1 after release B", b_dn_req, 0);

        fork
            begin
                send_a(8'h5A); send_a(8'h00); send_a(8'hFF); send_a(8'hA5);
                send_a(8'h01); send_a(8'h80); send_a(8'h5A); send_a(8'h3C);
            end
            begin
                send_b(8'hC3); send_b(8'hFF); send_b(8'h00); send_b(8'h7E);
                send_b(8'h81); send_b(8'h81); send_b(8'h12);
            end
        join
        repeat (6) @(negedge clk);

        // R7: data wiggles with no request event
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            a_up_data = W'(i * 37 + 5);
            b_up_data = W'(i * 53 + 9);
        end
        repeat (8) @(negedge clk);
        check(!a_dn_req && a_dn_data == last_a, "R7 idle data A", a_dn_data, last_a);
        check(b_dn_req == b_dn_ack && b_dn_data == last_b, "R7 idle data B", b_dn_data, last_b);

        check(got_a == 8 && qa.size() == 0, "R8 count A", got_a, 8);
        check(got_b == 7 && qb.size() == 0, "R5 count B", got_b, 7);
        check(a_up_ack == a_up_req, "R2 all events acked", a_up_ack, a_up_req);
        finish_run();
    end
endmodule